// File: doc/BRIEF.md
# Trip Assertion Delay

This block sits in the path of an active-low protection trip. It holds back the assertion (falling) edge of the trip by a programmable number of clock cycles, and it lets the release (rising) edge through in the same cycle. A trip that does not stay low long enough never reaches the output. This lets a power stage ignore short noise spikes on a comparator-driven fault line and still recover at once when the fault clears.

Inside the block a counter runs while the trip input is low and is forced to zero while the input is high. It stops when it reaches the match value. A one-bit state flag is cleared in the cycle after the counter equals the match value. It is set again when the input shows a rising edge. The output is the OR of that flag and the rising-edge event, so a release does not wait for the flag to update.

Top module: `trip_delay`

## Requirements
- R1: After synchronous reset, with the trip input high, the output is high (no trip) and the first trip after reset gets the full programmed delay.
- R2: With match value M, a trip input that falls and then stays low drives the output low exactly M+1 clock cycles after the fall. The output stays low for as long as the input stays low.
- R3: A match value of 0 drives the output low one clock cycle after the input falls.
- R4: A low pulse on the trip input that lasts M+1 cycles or fewer causes no change at the output.
- R5: Whenever the trip input is high the output is high in the same cycle, including the cycle in which a release edge arrives.
- R6: The counter stops at the match value and does not wrap, so a trip held low for more than 2^16 cycles keeps the output low the whole time.
- R7: A single high cycle between two low periods clears the count, so the second low period gets the full delay again.
- R8: A low pulse of exactly M+2 cycles produces an output low pulse of exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trip_n_in | input | 1 | Raw trip, active low |
| match_val | input | CNT_W (16) | Delay setting M; the output asserts M+1 cycles after the input falls |
| trip_n_out | output | 1 | Delayed trip, active low |

## Verification
The match event (the counter reaching M) and the release edge can fall on adjacent cycles. When the input rises on the cycle right after the match, the state flag is cleared in that same cycle, but the combinational release term covers it. The bench provokes this with low pulses of exactly M+1 and M+2 cycles. It expects no output pulse for the first and exactly one low cycle for the second. Every cycle's output is compared against the count of consecutive low input cycles, which the bench computes from the requirements.

// File: rtl/trip_delay.sv
module trip_delay #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trip_n_in,
  input  logic [CNT_W-1:0] match_val,
  output logic             trip_n_out
);

  logic [CNT_W-1:0] cnt_q;
  logic             in_q;
  logic             st_q;
  logic             ev_match;
  logic             ev_rise;

  assign ev_match   = ~trip_n_in & (cnt_q == match_val);
  assign ev_rise    = ~in_q & trip_n_in;
  assign trip_n_out = st_q | ev_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      in_q  <= 1'b1;
      st_q  <= 1'b1;
    end else begin
      in_q <= trip_n_in;
      st_q <= (st_q & ~ev_match) | (~st_q & ev_rise);
      if (trip_n_in)
        cnt_q <= '0;
      else if (cnt_q != match_val)
        cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

module trip_delay_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             trip_n_in,
  input logic [CNT_W-1:0] match_val,
  input logic             trip_n_out
);

  // R5
  high_pass_chk: assert property (@(posedge clk) disable iff (rst)
    trip_n_in |-> trip_n_out);

  // R2
  fall_needs_low_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(trip_n_out) |-> (!trip_n_in && $past(!trip_n_in)));

  // R2
  hold_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!trip_n_out && !trip_n_in) |=> (trip_n_in || !trip_n_out));

  // R3
  zero_delay_chk: assert property (@(posedge clk) disable iff (rst)
    (match_val == '0 && !trip_n_in) |=> (trip_n_in || !trip_n_out));

  // R1
  rise_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(trip_n_in) |-> trip_n_out);

endmodule

bind trip_delay trip_delay_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .trip_n_in(trip_n_in),
  .match_val(match_val), .trip_n_out(trip_n_out)
);

// File: tb/trip_delay_tb.sv
module trip_delay_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trip_n_in = 1'b1;
  logic [15:0] match_val = 16'd10;
  logic        trip_n_out;

  int    checks = 0;
  int    errors = 0;
  int    low_run = 0;
  int    cyc = 0;
  bit    done = 1'b0;
  bit    exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  trip_delay u_dut (
    .clk(clk), .rst(rst), .trip_n_in(trip_n_in),
    .match_val(match_val), .trip_n_out(trip_n_out)
  );

  task automatic drive(input bit lvl, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      trip_n_in = lvl;
      if (lvl) low_run = 0;
      else low_run++;
      exp_q.push_back(lvl ? 1'b1 : !(low_run >= int'(match_val) + 2));
      tag_q.push_back(tag);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #2;
      if (exp_q.size() > 0) begin
        bit    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (trip_n_out !== e) begin
          errors++;
          $display("FAIL %s cycle %0d: trip_n_out=%b expected=%b", t, cyc, trip_n_out, e);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    drive(1'b1, 5, "R1");
    drive(1'b0, 20, "R1");
    drive(1'b1, 3, "R5");
    drive(1'b0, 25, "R2");
    drive(1'b1, 3, "R5");
    match_val = 16'd0;
    drive(1'b0, 5, "R3");
    drive(1'b1, 2, "R5");
    drive(1'b0, 1, "R3");
    drive(1'b1, 2, "R3");
    match_val = 16'd10;
    drive(1'b0, 11, "R4");
    drive(1'b1, 2, "R4");
    drive(1'b0, 5, "R4");
    drive(1'b1, 2, "R4");
    drive(1'b0, 12, "R8");
    drive(1'b1, 3, "R8");
    match_val = 16'd3;
    drive(1'b0, 4, "R7");
    drive(1'b1, 1, "R7");
    drive(1'b0, 8, "R7");
    drive(1'b1, 2, "R5");
    match_val = 16'd200;
    drive(1'b0, 250, "R2");
    drive(1'b1, 2, "R5");
    match_val = 16'd5;
    drive(1'b0, 70000, "R6");
    drive(1'b1, 3, "R6");
    drive(1'b0, 10, "R6");
    drive(1'b1, 2, "R5");
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule